// File: doc/BRIEF.md
# Paged Program Counter Fetch Sequencer

This block is the front end of a small 8-bit processor whose code store is split into 256-byte pages. It holds the fetch address as two registers: a page byte and an offset byte. When the offset rolls over, a carry moves into the page byte. Each cycle it asks a synchronous, byte-wide code memory for one byte. It gathers the returned bytes into complete instructions of one, two or three bytes. Each finished instruction is presented on a set of output registers, qualified by a one-cycle valid strobe.

Control transfers use the upper nibble of the opcode. When that nibble is at or above a configured class boundary, the instruction is a jump, call or index. Such an instruction loads both address registers with its target, and fetching continues from there with no bubble. The target format depends on a parameter:
- In the default short format, the target is 12 bits: the low nibble of the opcode, then the second byte.
- In the wide format, used for code stores above 4 KB, the instruction is three bytes long and the target is a full 16 bits.

Sequential flow pays one cycle when an ordinary instruction finishes on the last offset of a page. The block raises a stall flag during that cycle, so a neighbour can account for the timing.

Top module: `paged_fetch_seq`

## Requirements
- R1: Reset is synchronous and active-high. While it is held, and in the first cycle after it is released, `mem_addr` is 0x0000 and `instr_valid` and `stall` are low. A one-byte instruction at 0x0000 is strobed after the second rising edge following release.
- R2: The memory is read synchronously: the address driven in one cycle returns its byte on `mem_rdata` in the next cycle. Fetch runs at one byte per cycle. When no penalty applies, consecutive valid strobes are separated by exactly the length, in bytes, of the later instruction.
- R3: An opcode whose upper nibble is below `JUMP_NIB_MIN` (default 8) is an ordinary instruction. Its length is set by opcode bits [1:0]: 00 gives 1 byte, 11 gives 3 bytes, and 01 or 10 gives 2 bytes. `instr_op` carries the opcode, `instr_arg1` the second byte and `instr_arg2` the third byte. Any argument byte the instruction does not have reads as zero.
- R4: An opcode whose upper nibble is at or above `JUMP_NIB_MIN` is a control transfer and sets `instr_jump`. With `WIDE_JUMP`=0 it is 2 bytes long. Its target is {4'h0, opcode[3:0], second byte}.
- R5: With `WIDE_JUMP`=1 a control transfer is 3 bytes long. Its target is {second byte, third byte}, and the opcode's low nibble plays no part in the target.
- R6: After a control transfer, the next instruction is fetched from the target. Its strobe follows the transfer's strobe by exactly its own length, with no penalty, even when the target is on another page.
- R7: Stepping past offset 0xFF clears the offset and adds one to the page. An instruction whose bytes straddle a page boundary is assembled with no extra cycle.
- R8: When an ordinary instruction's last byte sits at offset 0xFF, the following instruction's strobe comes one cycle later than R2 gives.
- R9: `stall` is high for exactly one cycle per page-end penalty: the cycle in which the penalised instruction's strobe is high. In that cycle `mem_addr` holds the new page's offset 0x00. `stall` is low at all other times.
- R10: A control transfer whose last byte sits at offset 0xFF causes no penalty and no `stall`.
- R11: `instr_pc` gives the address of the instruction's first byte, and `instr_len` its length in bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Code memory read address (page byte, then offset byte) |
| mem_rdata | input | 8 | Byte returned for the address driven one cycle earlier |
| instr_valid | output | 1 | One-cycle strobe for a completed instruction |
| instr_pc | output | 16 | Address of the instruction's first byte |
| instr_op | output | 8 | Opcode byte |
| instr_arg1 | output | 8 | Second byte, or zero |
| instr_arg2 | output | 8 | Third byte, or zero |
| instr_len | output | 2 | Instruction length, 1 to 3 |
| instr_jump | output | 1 | Instruction is a jump, call or index |
| stall | output | 1 | Page-end penalty cycle |

## Verification
The bench measures the cycle gap between consecutive strobes. A design that drops or doubles the page-end penalty, or charges it to jumps, moves a strobe by one cycle and fails the gap checks.

The straddling three-byte case and the case of a jump ending on offset 0xFF catch a design that tests the wrong byte's offset. Such a design raises a stall where none belongs.

Short-format targets that take their page bits from the opcode's low nibble, and wide-format targets, catch a mis-assembled target, which shows up as a wrong `instr_pc` after the transfer. Opcodes near the class boundary (0x7F as a 3-byte ordinary instruction) catch a misplaced jump-class compare.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

    localparam int PAGE_W = 8;
    localparam int OFS_W  = 8;
    localparam int ADDR_W = PAGE_W + OFS_W;
    localparam int BYTE_W = 8;
    localparam int SHORT_TGT_W = 12;

    localparam logic [OFS_W-1:0] OFS_LAST = '1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [1:0]        len_t;

    typedef enum logic [1:0] {
        SLOT_OP = 2'd0,
        SLOT_A1 = 2'd1,
        SLOT_A2 = 2'd2
    } slot_e;

    typedef struct packed {
        addr_t pc;
        byte_t op;
        byte_t a1;
        byte_t a2;
        len_t  len;
        logic  jump;
    } instr_t;

    function automatic logic is_xfer(byte_t op, logic [3:0] nib_min);
        return op[BYTE_W-1:BYTE_W-4] >= nib_min;
    endfunction

    function automatic len_t op_length(byte_t op, logic [3:0] nib_min, logic wide);
        if (is_xfer(op, nib_min))
            return wide ? 2'd3 : 2'd2;
        case (op[1:0])
            2'b00:   return 2'd1;
            2'b11:   return 2'd3;
            default: return 2'd2;
        endcase
    endfunction

    function automatic addr_t step_addr(addr_t a);
        logic [OFS_W:0]      ofs_n;
        logic [PAGE_W-1:0]   page_n;
        ofs_n  = {1'b0, a[OFS_W-1:0]} + (OFS_W+1)'(1);
        page_n = a[ADDR_W-1:OFS_W] + PAGE_W'(ofs_n[OFS_W]);
        return {page_n, ofs_n[OFS_W-1:0]};
    endfunction

endpackage

// File: rtl/pcf_pc_unit.sv
module pcf_pc_unit
    import pcf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  redirect,
    input  addr_t tgt,
    output addr_t fetch_addr
);

    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  ofs_q;
    addr_t             base;

    always_comb begin
        base       = redirect ? tgt : {page_q, ofs_q};
        fetch_addr = base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            ofs_q  <= '0;
        end else if (adv) begin
            {page_q, ofs_q} <= step_addr(base);
        end
    end

endmodule

// File: rtl/pcf_assembler.sv
module pcf_assembler
    import pcf_pkg::*;
#(
    parameter logic [3:0] NIB_MIN = 4'h8,
    parameter bit         WIDE    = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   byte_vld,
    input  byte_t  byte_in,
    input  addr_t  byte_addr,
    output logic   done,
    output instr_t rec,
    output addr_t  jump_tgt
);

    slot_e slot_q;
    byte_t op_q;
    byte_t a1_q;
    addr_t pc_q;
    byte_t cur_op;
    len_t  cur_len;

    always_comb begin
        cur_op  = (slot_q == SLOT_OP) ? byte_in : op_q;
        cur_len = op_length(cur_op, NIB_MIN, WIDE);
        done    = byte_vld && ((2'(slot_q) + 2'd1) == cur_len);

        rec.pc   = (slot_q == SLOT_OP) ? byte_addr : pc_q;
        rec.op   = cur_op;
        rec.len  = cur_len;
        rec.jump = is_xfer(cur_op, NIB_MIN);
        if (cur_len == 2'd1)
            rec.a1 = '0;
        else
            rec.a1 = (slot_q == SLOT_A1) ? byte_in : a1_q;
        rec.a2 = (cur_len == 2'd3) ? byte_in : '0;
    end

    generate
        if (WIDE) begin : g_wide_tgt
            assign jump_tgt = {a1_q, byte_in};
        end else begin : g_short_tgt
            assign jump_tgt = {{(ADDR_W-SHORT_TGT_W){1'b0}}, op_q[3:0], byte_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_OP;
            op_q   <= '0;
            a1_q   <= '0;
            pc_q   <= '0;
        end else if (byte_vld) begin
            if (done) begin
                slot_q <= SLOT_OP;
            end else begin
                case (slot_q)
                    SLOT_OP: slot_q <= SLOT_A1;
                    SLOT_A1: slot_q <= SLOT_A2;
                    default: slot_q <= SLOT_OP;
                endcase
            end
            if (slot_q == SLOT_OP) begin
                op_q <= byte_in;
                pc_q <= byte_addr;
            end
            if (slot_q == SLOT_A1)
                a1_q <= byte_in;
        end
    end

endmodule

// File: rtl/pcf_seq_ctrl.sv
module pcf_seq_ctrl
    import pcf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  done,
    input  logic  is_jump,
    input  addr_t jump_tgt,
    input  addr_t fetch_addr,
    output logic  byte_vld,
    output addr_t byte_addr,
    output logic  redirect,
    output addr_t tgt,
    output logic  adv,
    output logic  stall
);

    logic  pend_q;
    logic  stall_q;
    addr_t baddr_q;
    logic  penalty;

    always_comb begin
        penalty   = done && !is_jump && (baddr_q[OFS_W-1:0] == OFS_LAST);
        redirect  = done && is_jump;
        tgt       = jump_tgt;
        adv       = !penalty;
        byte_vld  = pend_q;
        byte_addr = baddr_q;
        stall     = stall_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            stall_q <= 1'b0;
            baddr_q <= '0;
        end else begin
            pend_q  <= !penalty;
            stall_q <= penalty;
            if (adv)
                baddr_q <= fetch_addr;
        end
    end

endmodule

// File: rtl/pcf_issue_reg.sv
module pcf_issue_reg
    import pcf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   done,
    input  instr_t rec,
    output logic   valid,
    output instr_t held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            held  <= '0;
        end else begin
            valid <= done;
            if (done)
                held <= rec;
        end
    end

endmodule

// File: rtl/paged_fetch_seq.sv
module paged_fetch_seq
    import pcf_pkg::*;
#(
    parameter logic [3:0] JUMP_NIB_MIN = 4'h8,
    parameter bit         WIDE_JUMP    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              instr_valid,
    output logic [ADDR_W-1:0] instr_pc,
    output logic [BYTE_W-1:0] instr_op,
    output logic [BYTE_W-1:0] instr_arg1,
    output logic [BYTE_W-1:0] instr_arg2,
    output logic [1:0]        instr_len,
    output logic              instr_jump,
    output logic              stall
);

    logic   byte_vld;
    addr_t  byte_addr;
    logic   done;
    instr_t rec;
    addr_t  jump_tgt;
    logic   redirect;
    addr_t  tgt;
    logic   adv;
    addr_t  fetch_addr;
    instr_t held;

    pcf_pc_unit u_pc (
        .clk        (clk),
        .rst        (rst),
        .adv        (adv),
        .redirect   (redirect),
        .tgt        (tgt),
        .fetch_addr (fetch_addr)
    );

    pcf_assembler #(
        .NIB_MIN (JUMP_NIB_MIN),
        .WIDE    (WIDE_JUMP)
    ) u_asm (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .byte_in   (mem_rdata),
        .byte_addr (byte_addr),
        .done      (done),
        .rec       (rec),
        .jump_tgt  (jump_tgt)
    );

    pcf_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .done       (done),
        .is_jump    (rec.jump),
        .jump_tgt   (jump_tgt),
        .fetch_addr (fetch_addr),
        .byte_vld   (byte_vld),
        .byte_addr  (byte_addr),
        .redirect   (redirect),
        .tgt        (tgt),
        .adv        (adv),
        .stall      (stall)
    );

    pcf_issue_reg u_out (
        .clk   (clk),
        .rst   (rst),
        .done  (done),
        .rec   (rec),
        .valid (instr_valid),
        .held  (held)
    );

    assign mem_addr   = fetch_addr;
    assign instr_pc   = held.pc;
    assign instr_op   = held.op;
    assign instr_arg1 = held.a1;
    assign instr_arg2 = held.a2;
    assign instr_len  = held.len;
    assign instr_jump = held.jump;

endmodule

// File: rtl/pcf_fetch_chk.sv
module pcf_fetch_chk
    import pcf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              instr_valid,
    input logic [ADDR_W-1:0] instr_pc,
    input logic [BYTE_W-1:0] instr_arg2,
    input logic [1:0]        instr_len,
    input logic              instr_jump,
    input logic              stall
);

    logic [OFS_W-1:0] end_ofs;
    assign end_ofs = instr_pc[OFS_W-1:0] + OFS_W'(instr_len) - OFS_W'(1);

    // R1
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!instr_valid && !stall && mem_addr == '0));

    // R9
    stall_single_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R8
    stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (instr_valid && !instr_jump && end_ofs == OFS_LAST));

    // R10
    jump_nostall_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_jump) |-> !stall);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (mem_addr == $past(mem_addr) && mem_addr[OFS_W-1:0] == '0));

    // R3
    arg2_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_len != 2'd3) |-> (instr_arg2 == '0 && instr_len != 2'd0));

endmodule

bind paged_fetch_seq pcf_fetch_chk u_fetch_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_addr    (mem_addr),
    .instr_valid (instr_valid),
    .instr_pc    (instr_pc),
    .instr_arg2  (instr_arg2),
    .instr_len   (instr_len),
    .instr_jump  (instr_jump),
    .stall       (stall)
);

// File: tb/test_paged_fetch_seq.sv
`timescale 1ns/1ps
module test_paged_fetch_seq;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [15:0] n_addr, n_pc, w_addr, w_pc;
    logic [7:0]  n_data, n_op, n_a1, n_a2, w_data, w_op, w_a1, w_a2;
    logic [1:0]  n_len, w_len;
    logic        n_valid, n_jmp, n_stall, w_valid, w_jmp, w_stall;

    paged_fetch_seq i_paged_fetch_seq (
        .clk(clk), .rst(rst), .mem_addr(n_addr), .mem_rdata(n_data),
        .instr_valid(n_valid), .instr_pc(n_pc), .instr_op(n_op),
        .instr_arg1(n_a1), .instr_arg2(n_a2), .instr_len(n_len),
        .instr_jump(n_jmp), .stall(n_stall)
    );

    paged_fetch_seq #(.WIDE_JUMP(1'b1)) i_paged_fetch_seq_wide (
        .clk(clk), .rst(rst), .mem_addr(w_addr), .mem_rdata(w_data),
        .instr_valid(w_valid), .instr_pc(w_pc), .instr_op(w_op),
        .instr_arg1(w_a1), .instr_arg2(w_a2), .instr_len(w_len),
        .instr_jump(w_jmp), .stall(w_stall)
    );

    logic [7:0] nmem [int];
    logic [7:0] wmem [int];

    function automatic logic [7:0] nrd(int a);
        return nmem.exists(a) ? nmem[a] : 8'h00;
    endfunction
    function automatic logic [7:0] wrd(int a);
        return wmem.exists(a) ? wmem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        n_data <= nrd(int'(n_addr));
        w_data <= wrd(int'(w_addr));
    end

    int cyc;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    int          ncap, wcap, nstall;
    int          cap_cyc [32];
    logic [15:0] cap_pc  [32];
    logic [7:0]  cap_op  [32];
    logic [7:0]  cap_a1  [32];
    logic [7:0]  cap_a2  [32];
    logic [1:0]  cap_len [32];
    logic        cap_jmp [32];
    logic        cap_stl [32];
    int          wc_cyc  [32];
    logic [15:0] wc_pc   [32];
    logic [1:0]  wc_len  [32];
    logic        wc_jmp  [32];

    always @(negedge clk) begin
        if (!rst) begin
            if (n_stall) nstall = nstall + 1;
            if (n_valid && ncap < 32) begin
                cap_cyc[ncap] = cyc;  cap_pc[ncap]  = n_pc;
                cap_op[ncap]  = n_op; cap_a1[ncap]  = n_a1;
                cap_a2[ncap]  = n_a2; cap_len[ncap] = n_len;
                cap_jmp[ncap] = n_jmp; cap_stl[ncap] = n_stall;
                ncap = ncap + 1;
            end
            if (w_valid && wcap < 32) begin
                wc_cyc[wcap] = cyc; wc_pc[wcap] = w_pc;
                wc_len[wcap] = w_len; wc_jmp[wcap] = w_jmp;
                wcap = wcap + 1;
            end
        end
    end

    int compared = 0;
    int mismatched = 0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        compared = compared + 1;
        if (act !== exp) begin
            mismatched = mismatched + 1;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic clear_mem();
        nmem.delete();
        wmem.delete();
    endtask

    task automatic release_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ncap = 0; wcap = 0; nstall = 0;
        rst = 1'b0;
    endtask

    // gap < 0 means no gap check (first strobe)
    task automatic exp_n(string tag, int k, int pc, int op, int len, int jmp, int gap, int stl);
        chk({tag, " strobe present"}, 32'(ncap > k), 32'd1);
        if (ncap > k) begin
            chk({tag, " pc"}, 32'(cap_pc[k]), 32'(pc));
            chk({tag, " op"}, 32'(cap_op[k]), 32'(op));
            chk({tag, " len"}, 32'(cap_len[k]), 32'(len));
            chk({tag, " jump"}, 32'(cap_jmp[k]), 32'(jmp));
            chk({tag, " stall"}, 32'(cap_stl[k]), 32'(stl));
            if (gap >= 0 && k > 0)
                chk({tag, " gap"}, 32'(cap_cyc[k] - cap_cyc[k-1]), 32'(gap));
        end
    endtask

    task automatic t_reset();
        clear_mem();
        nmem[0] = 8'h10;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 valid in reset", 32'(n_valid), 32'd0);
        chk("R1 addr in reset", 32'(n_addr), 32'd0);
        chk("R1 stall in reset", 32'(n_stall), 32'd0);
        release_reset();
        chk("R1 addr after release", 32'(n_addr), 32'd0);
        chk("R1 valid after release", 32'(n_valid), 32'd0);
        repeat (6) @(negedge clk);
        chk("R1 first strobe cycle", 32'(cap_cyc[0]), 32'd2);
        exp_n("R1/R11 first instr", 0, 16'h0000, 8'h10, 1, 0, -1, 0);
    endtask

    task automatic t_seq();
        clear_mem();
        nmem[0] = 8'h10;
        nmem[1] = 8'h22; nmem[2] = 8'hAA;
        nmem[3] = 8'h33; nmem[4] = 8'hBB; nmem[5] = 8'hCC;
        nmem[6] = 8'h7F; nmem[7] = 8'h01; nmem[8] = 8'h02;
        nmem[9] = 8'h40;
        release_reset();
        repeat (16) @(negedge clk);
        exp_n("R3 len1", 0, 16'h0000, 8'h10, 1, 0, -1, 0);
        if (ncap > 0) chk("R3 len1 arg1 zero", 32'(cap_a1[0]), 32'd0);
        exp_n("R2 len2", 1, 16'h0001, 8'h22, 2, 0, 2, 0);
        if (ncap > 1) begin
            chk("R3 len2 arg1", 32'(cap_a1[1]), 32'hAA);
            chk("R3 len2 arg2 zero", 32'(cap_a2[1]), 32'd0);
        end
        exp_n("R2 len3", 2, 16'h0003, 8'h33, 3, 0, 3, 0);
        if (ncap > 2) begin
            chk("R3 len3 arg1", 32'(cap_a1[2]), 32'hBB);
            chk("R3 len3 arg2", 32'(cap_a2[2]), 32'hCC);
        end
        exp_n("R3 op 7F ordinary", 3, 16'h0006, 8'h7F, 3, 0, 3, 0);
        exp_n("R11 pc after mix", 4, 16'h0009, 8'h40, 1, 0, 1, 0);
    endtask

    task automatic t_penalty();
        clear_mem();
        nmem[0] = 8'h80; nmem[1] = 8'hFD;
        nmem[16'h0FD] = 8'h13; nmem[16'h0FE] = 8'h11; nmem[16'h0FF] = 8'h22;
        nmem[16'h100] = 8'h54;
        release_reset();
        repeat (20) @(negedge clk);
        exp_n("R4 short jump", 0, 16'h0000, 8'h80, 2, 1, -1, 0);
        exp_n("R6 target no penalty", 1, 16'h00FD, 8'h13, 3, 0, 3, 1);
        exp_n("R8 after page end", 2, 16'h0100, 8'h54, 1, 0, 2, 0);
        exp_n("R7 next page seq", 3, 16'h0101, 8'h00, 1, 0, 1, 0);
        chk("R9 stall count", 32'(nstall), 32'd1);
    endtask

    task automatic t_mid_cross();
        clear_mem();
        nmem[0] = 8'h81; nmem[1] = 8'hFE;
        nmem[16'h1FE] = 8'h03; nmem[16'h1FF] = 8'hA1; nmem[16'h200] = 8'hB2;
        nmem[16'h201] = 8'h08;
        release_reset();
        repeat (16) @(negedge clk);
        exp_n("R6 jump across page", 1, 16'h01FE, 8'h03, 3, 0, 3, 0);
        if (ncap > 1) chk("R7 straddle arg2", 32'(cap_a2[1]), 32'hB2);
        exp_n("R7 straddle no penalty", 2, 16'h0201, 8'h08, 1, 0, 1, 0);
        chk("R9 no stall on straddle", 32'(nstall), 32'd0);
    endtask

    task automatic t_jump_edge();
        clear_mem();
        nmem[0] = 8'h82; nmem[1] = 8'hFE;
        nmem[16'h2FE] = 8'h9A; nmem[16'h2FF] = 8'h10;
        release_reset();
        repeat (14) @(negedge clk);
        exp_n("R10 jump at page end", 1, 16'h02FE, 8'h9A, 2, 1, 2, 0);
        exp_n("R4 nibble target", 2, 16'h0A10, 8'h00, 1, 0, 1, 0);
        chk("R10 no stall", 32'(nstall), 32'd0);
    endtask

    task automatic t_len1_edge();
        clear_mem();
        nmem[0] = 8'h83; nmem[1] = 8'hFF;
        nmem[16'h3FF] = 8'h04;
        nmem[16'h400] = 8'h0C;
        release_reset();
        repeat (14) @(negedge clk);
        exp_n("R8 len1 at page end", 1, 16'h03FF, 8'h04, 1, 0, 1, 1);
        exp_n("R8 delayed next", 2, 16'h0400, 8'h0C, 1, 0, 2, 0);
        chk("R9 single stall", 32'(nstall), 32'd1);
    endtask

    task automatic t_wide();
        clear_mem();
        wmem[0] = 8'h9F; wmem[1] = 8'h12; wmem[2] = 8'h34;
        wmem[16'h1234] = 8'h01; wmem[16'h1235] = 8'h55;
        release_reset();
        repeat (14) @(negedge clk);
        chk("R5 wide strobes", 32'(wcap > 1), 32'd1);
        if (wcap > 1) begin
            chk("R5 wide jump len", 32'(wc_len[0]), 32'd3);
            chk("R5 wide jump flag", 32'(wc_jmp[0]), 32'd1);
            chk("R5 wide target pc", 32'(wc_pc[1]), 32'h1234);
            chk("R5 target len", 32'(wc_len[1]), 32'd2);
            chk("R5 gap", 32'(wc_cyc[1] - wc_cyc[0]), 32'd2);
        end
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_seq();
        t_penalty();
        t_mid_cross();
        t_jump_edge();
        t_len1_edge();
        t_wide();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared = compared + 1;
            mismatched = mismatched + 1;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule